// File: doc/BRIEF.md
# Command-Gated Serial Register Port

This block is the serial slave front end of a converter-style device. An external master talks to it over chip select, a serial clock that idles high, a data-in line and a data-out line with its own drive enable. Every exchange opens with an eight-bit command. The command decides whether the single transfer that follows is a read or a write, and which internal register it reaches. Once that transfer is done, the port waits for a command again. The register file has three parts: two eight-bit configuration registers (setup and clock control) and a sixteen-bit result register. The result register is loaded from a stand-in sample source through a one-cycle strobe.

An active-low data-ready output tells the master when a fresh result can be fetched. The same flag can be read back as the top bit of the command register, so a master that ties chip select low and uses only three wires can still poll it. A long unbroken run of ones on data-in brings a lost port back to the wait-for-command state without touching any stored value. The serial pins pass through a parameterised synchroniser and are sampled on the fast system clock, so the serial clock must stay well below the system clock.

Top module: `cmd_serial_port`

## Requirements
- R1: After reset, `drdy_n` is 1, setup reads back as SETUP_RST, clock control as CLK_RST, and the first eight bits clocked in are taken as a command.
- R2: Serial bits move MSB first. Data-in is sampled on the serial clock's rising edge and data-out changes on its falling edge. Command bit 7 must be written 0. Bits 6:4 select the target: 0 command, 1 setup, 2 clock control, 3 result, 4 to 7 unassigned. Bit 3 is 1 for read and 0 for write. Bits 2:0 carry no function.
- R3: A write command to setup or clock control loads the next eight bits into that register, after which the port waits for a command. A write command that selects target 0 is complete in itself.
- R4: A read command shifts out the selected register over as many clocks as its width (16 for the result, 8 otherwise). Unassigned targets read as zero. Writes to the result or to unassigned targets take their full width and change nothing.
- R5: On a new-result strobe, `drdy_n` is 1 in the next cycle. The result is loaded in the cycle after that, and `drdy_n` goes to 0.
- R6: `drdy_n` returns to 1 when all sixteen bits of a result read have been clocked. A repeated read returns the same value until the next load.
- R7: Reading target 0 returns the `drdy_n` level in bit 7 and bits 6:0 of the read command itself.
- R8: The 32nd consecutive sampled 1 on data-in puts the port into the wait-for-command state and changes no register. Further ones are ignored, the next 0 is the first bit of a command, and any sampled 0 restarts the run count.
- R9: Chip select high drops `dout_en`, discards any partly clocked byte and keeps the pending command. The next transfer then starts again from its first bit.
- R10: With chip select held low throughout, commands and transfers follow each other back to back on three wires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Drive enable for dout, high while selected |
| drdy_n | output | 1 | Active-low result-ready flag |
| new_valid | input | 1 | One-cycle strobe for a new result |
| new_data | input | DATA_W | Result value carried with the strobe |
| setup_q | output | REG_W | Setup register contents |
| clkdiv_q | output | REG_W | Clock-control register contents |

## Verification
A wrong phase or bit count makes every byte after it land on the wrong target. The first register read that follows then returns misaligned data, and a configuration output changes at an idle time when the per-cycle comparison expects it to hold. Faults in the data-ready logic show within one or two cycles of a strobe or of the last clock of a result read, because the flag is compared on every cycle. A faulty ones-run counter shows as a failed resync (the next read comes back shifted) or as a configuration change during the run of ones.

// File: rtl/cmd_serial_port_pkg.sv
package cmd_serial_port_pkg;
   localparam int CMD_W = 8;
   localparam logic [2:0] SEL_CMD   = 3'd0;
   localparam logic [2:0] SEL_SETUP = 3'd1;
   localparam logic [2:0] SEL_CLK   = 3'd2;
   localparam logic [2:0] SEL_RES   = 3'd3;
   typedef enum logic {PH_CMD, PH_XFER} phase_e;
endpackage

// File: rtl/cp_insync.sv
module cp_insync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cp_edge.sv
module cp_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   output logic rise,
   output logic fall
);
   logic prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= s;
   end
   assign rise = s & ~prev;
   assign fall = ~s & prev;
endmodule

// File: rtl/cp_onesrun.sv
module cp_onesrun #(
   parameter int RUN_LEN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic bit_in,
   output logic fire,
   output logic hold
);
   localparam int CNT_W = $clog2(RUN_LEN + 1);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(RUN_LEN);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (sample) begin
         if (!bit_in)          cnt <= '0;
         else if (cnt != TOP)  cnt <= cnt + CNT_W'(1);
      end
   end
   assign fire = sample & bit_in & (cnt == TOP - CNT_W'(1));
   assign hold = sample & bit_in & (cnt == TOP);
endmodule

// File: rtl/cp_resultreg.sv
module cp_resultreg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         rd_done,
   output logic [W-1:0] result_q,
   output logic         drdy_n
);
   logic [W-1:0] stage;
   logic         pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage    <= '0;
         pend     <= 1'b0;
         result_q <= '0;
         drdy_n   <= 1'b1;
      end else if (load) begin
         stage  <= load_data;
         pend   <= 1'b1;
         drdy_n <= 1'b1;
      end else if (pend) begin
         result_q <= stage;
         pend     <= 1'b0;
         drdy_n   <= 1'b0;
      end else if (rd_done) begin
         drdy_n <= 1'b1;
      end
   end
endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port
   import cmd_serial_port_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          REG_W       = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          RUN_LEN     = 32,
   parameter logic [7:0]  SETUP_RST   = 8'h01,
   parameter logic [7:0]  CLK_RST     = 8'h05
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   output logic              dout,
   output logic              dout_en,
   output logic              drdy_n,
   input  logic              new_valid,
   input  logic [DATA_W-1:0] new_data,
   output logic [REG_W-1:0]  setup_q,
   output logic [REG_W-1:0]  clkdiv_q
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam logic [CW-1:0] LAST_CMD = CW'(CMD_W - 1);
   localparam logic [CW-1:0] LAST_REG = CW'(REG_W - 1);
   localparam logic [CW-1:0] LAST_DAT = CW'(DATA_W - 1);

   generate
      if (REG_W < CMD_W || DATA_W < REG_W || RUN_LEN < 2 || SYNC_STAGES < 0) begin : g_bad_cfg
         $error("cmd_serial_port: unsupported parameter set");
      end
   endgenerate

   logic cs_n_s, sclk_s, din_s, rise, fall, sample, drive;
   logic rs_fire, rs_hold, rd_done;
   logic [DATA_W-1:0] result_q, rd_value;

   cp_insync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q({cs_n_s, sclk_s, din_s}));
   cp_edge u_edge (.clk(clk), .rst_n(rst_n), .s(sclk_s), .rise(rise), .fall(fall));

   assign sample  = rise & ~cs_n_s;
   assign drive   = fall & ~cs_n_s;
   assign dout_en = ~cs_n_s;

   cp_onesrun #(.RUN_LEN(RUN_LEN)) u_run (
      .clk(clk), .rst_n(rst_n), .sample(sample), .bit_in(din_s),
      .fire(rs_fire), .hold(rs_hold));

   phase_e            phase;
   logic [6:0]        cmd_q;
   logic [CW-1:0]     bitcnt;
   logic [REG_W-2:0]  sh_in;
   logic [DATA_W-1:0] sh_out;
   logic [2:0]        sel;
   logic              rd, last_bit, in_xfer, bit_idle;

   assign sel      = cmd_q[6:4];
   assign rd       = cmd_q[3];
   assign in_xfer  = (phase == PH_XFER);
   assign bit_idle = (bitcnt == '0);
   assign last_bit = (sel == SEL_RES) ? (bitcnt == LAST_DAT) : (bitcnt == LAST_REG);
   assign rd_done  = sample & ~rs_fire & in_xfer & rd & (sel == SEL_RES) & last_bit;

   always_comb begin
      case (sel)
         SEL_CMD:   rd_value = DATA_W'({drdy_n, cmd_q}) << (DATA_W - CMD_W);
         SEL_SETUP: rd_value = DATA_W'(setup_q) << (DATA_W - REG_W);
         SEL_CLK:   rd_value = DATA_W'(clkdiv_q) << (DATA_W - REG_W);
         SEL_RES:   rd_value = result_q;
         default:   rd_value = '0;
      endcase
   end

   cp_resultreg #(.W(DATA_W)) u_res (
      .clk(clk), .rst_n(rst_n), .load(new_valid), .load_data(new_data),
      .rd_done(rd_done), .result_q(result_q), .drdy_n(drdy_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         cmd_q    <= '0;
         bitcnt   <= '0;
         sh_in    <= '0;
         setup_q  <= REG_W'(SETUP_RST);
         clkdiv_q <= REG_W'(CLK_RST);
      end else if (cs_n_s) begin
         bitcnt <= '0;
      end else if (sample) begin
         if (rs_fire) begin
            phase  <= PH_CMD;
            bitcnt <= '0;
         end else if (!rs_hold) begin
            sh_in <= {sh_in[REG_W-3:0], din_s};
            if (phase == PH_CMD) begin
               if (bitcnt == LAST_CMD) begin
                  bitcnt <= '0;
                  cmd_q  <= {sh_in[5:0], din_s};
                  phase  <= (sh_in[5:3] == SEL_CMD && !sh_in[2]) ? PH_CMD : PH_XFER;
               end else begin
                  bitcnt <= bitcnt + CW'(1);
               end
            end else if (last_bit) begin
               bitcnt <= '0;
               phase  <= PH_CMD;
               if (!rd && sel == SEL_SETUP) setup_q  <= {sh_in, din_s};
               if (!rd && sel == SEL_CLK)   clkdiv_q <= {sh_in, din_s};
            end else begin
               bitcnt <= bitcnt + CW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout   <= 1'b0;
         sh_out <= '0;
      end else if (drive) begin
         if (in_xfer && rd) begin
            if (bit_idle) begin
               dout   <= rd_value[DATA_W-1];
               sh_out <= rd_value << 1;
            end else begin
               dout   <= sh_out[DATA_W-1];
               sh_out <= sh_out << 1;
            end
         end else begin
            dout <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cmd_serial_port_chk.sv
module cmd_serial_port_chk #(
   parameter int DATA_W = 16,
   parameter int REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              new_valid,
   input logic              drdy_n,
   input logic              rd_done,
   input logic [DATA_W-1:0] result_q,
   input logic [REG_W-1:0]  setup_q,
   input logic [REG_W-1:0]  clkdiv_q,
   input logic              in_xfer,
   input logic              bit_idle,
   input logic              rs_fire
);
   // R5
   blank_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_valid |=> drdy_n);
   // R5
   ready_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(new_valid) && !new_valid) |=> !drdy_n);
   // R5
   load_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_q) |-> $past(drdy_n));
   // R6
   done_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && !new_valid && !$past(new_valid)) |=> drdy_n);
   // R3
   cfg_write_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(setup_q) || !$stable(clkdiv_q)) |-> $past(in_xfer));
   // R8
   resync_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fire |=> (!in_xfer && bit_idle));
   // R8
   resync_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_fire |=> ($stable(setup_q) && $stable(clkdiv_q)));
endmodule

bind cmd_serial_port cmd_serial_port_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .new_valid(new_valid), .drdy_n(drdy_n),
   .rd_done(rd_done), .result_q(result_q), .setup_q(setup_q),
   .clkdiv_q(clkdiv_q), .in_xfer(in_xfer), .bit_idle(bit_idle), .rs_fire(rs_fire));

// File: tb/sim_cmd_serial_port.sv
module sim_cmd_serial_port;
   localparam int HALF = 6;
   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, din = 1'b1;
   logic new_valid = 1'b0;
   logic [15:0] new_data = '0;
   logic dout, dout_en, drdy_n;
   logic [7:0] setup_q, clkdiv_q;

   int errs = 0, checks = 0, cyc = 0;
   bit busy = 1'b1;
   logic       exp_drdy = 1'b1;
   logic [7:0] exp_setup = 8'h01, exp_clk = 8'h05;
   logic [15:0] exp_res = '0;

   always #5 clk = ~clk;

   cmd_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .dout(dout), .dout_en(dout_en), .drdy_n(drdy_n),
      .new_valid(new_valid), .new_data(new_data),
      .setup_q(setup_q), .clkdiv_q(clkdiv_q));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison of the model while the port is idle (R1 R3 R5 R6)
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !busy) begin
         chk("R5/R6 drdy_n", {15'd0, drdy_n}, {15'd0, exp_drdy});
         chk("R3 setup",     {8'd0, setup_q}, {8'd0, exp_setup});
         chk("R3 clock",     {8'd0, clkdiv_q}, {8'd0, exp_clk});
      end
   end

   task automatic sbit(input logic b, output logic got);
      sclk = 1'b0; din = b;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      got = dout;
   endtask

   task automatic xfer(input int n, input logic [15:0] wv, output logic [15:0] rv);
      logic b;
      rv = '0;
      for (int i = n - 1; i >= 0; i--) begin
         sbit(wv[i], b);
         rv[i] = b;
      end
   endtask

   function automatic int width_of(input logic [2:0] sel);
      return (sel == 3'd3) ? 16 : 8;
   endfunction

   task automatic wr(input logic [2:0] sel, input logic [15:0] val);
      logic [15:0] junk;
      busy = 1'b1;
      xfer(8, {8'd0, 1'b0, sel, 4'b0000}, junk);
      xfer(width_of(sel), val, junk);
      if (sel == 3'd1) exp_setup = val[7:0];
      if (sel == 3'd2) exp_clk   = val[7:0];
      busy = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, input string req, input logic [15:0] exp);
      logic [15:0] got;
      busy = 1'b1;
      xfer(8, {8'd0, 1'b0, sel, 4'b1000}, got);
      xfer(width_of(sel), 16'd0, got);
      chk(req, got, exp);
      if (sel == 3'd3) exp_drdy = 1'b1;
      busy = 1'b0;
   endtask

   task automatic strobe(input logic [15:0] d);
      busy = 1'b1;
      new_valid = 1'b1; new_data = d;
      @(negedge clk);
      new_valid = 1'b0;
      chk("R5 blank after strobe", {15'd0, drdy_n}, 16'd1);
      @(negedge clk);
      chk("R5 ready after load", {15'd0, drdy_n}, 16'd0);
      exp_drdy = 1'b0; exp_res = d;
      busy = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [15:0] junk;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 drdy_n after reset", {15'd0, drdy_n}, 16'd1);
      chk("R1 dout_en deselected", {15'd0, dout_en}, 16'd0);
      chk("R1 setup reset value", {8'd0, setup_q}, 16'h0001);
      chk("R1 clock reset value", {8'd0, clkdiv_q}, 16'h0005);
      busy = 1'b0;
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 dout_en selected", {15'd0, dout_en}, 16'd1);

      // R1 R2 R3 first byte is a command; write then read back
      wr(3'd1, 16'h00A5);
      wr(3'd2, 16'h003C);
      rd(3'd1, "R2 read setup", 16'h00A5);
      rd(3'd2, "R4 read clock", 16'h003C);
      // R3 write command to target 0 completes alone, next byte is a command (R10 back to back)
      busy = 1'b1; xfer(8, 16'h0000, junk); busy = 1'b0;
      rd(3'd1, "R3 no-op command then read", 16'h00A5);

      // R7 command readback with flag high
      rd(3'd0, "R7 command readback flag high", 16'h0088);
      // R5 R6 new result and repeated reads
      strobe(16'h1234);
      rd(3'd0, "R7 command readback flag low", 16'h0008);
      rd(3'd3, "R6 first result read", 16'h1234);
      chk("R6 flag high after read", {15'd0, drdy_n}, 16'd1);
      rd(3'd3, "R6 repeated result read", 16'h1234);
      strobe(16'hBEEF);
      rd(3'd3, "R6 read after new load", 16'hBEEF);

      // R4 discarded writes and unassigned reads
      wr(3'd3, 16'h5555);
      rd(3'd3, "R4 result write discarded", 16'hBEEF);
      wr(3'd5, 16'h00FF);
      rd(3'd6, "R4 unassigned read zero", 16'h0000);
      rd(3'd1, "R4 setup kept after stray write", 16'h00A5);

      // R8 resync from a pending result write, then extra ones are ignored
      busy = 1'b1;
      xfer(8, 16'h0030, junk);
      xfer(16, 16'hFFFF, junk);
      xfer(16, 16'hFFFF, junk);
      xfer(8, 16'h00FF, junk);
      busy = 1'b0;
      rd(3'd1, "R8 setup intact after resync", 16'h00A5);
      rd(3'd2, "R8 clock intact after resync", 16'h003C);

      // R9 chip select abort mid byte keeps the pending target
      busy = 1'b1;
      xfer(8, 16'h0020, junk);
      xfer(4, 16'h000A, junk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 dout_en low on abort", {15'd0, dout_en}, 16'd0);
      chk("R9 clock unchanged by partial byte", {8'd0, clkdiv_q}, 16'h003C);
      cs_n = 1'b0;
      repeat (8) @(negedge clk);
      xfer(8, 16'h0077, junk);
      exp_clk = 8'h77;
      busy = 1'b0;
      rd(3'd2, "R9 transfer restarted from first bit", 16'h0077);

      repeat (10) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule